// File: doc/BRIEF.md
# Luma/Chroma Sync-Code Mapping Interleaver

This block is the parallel front end of a high-definition serial video transmitter. Each accepted input word is 20 bits wide and carries one luma sample in bits 19:10 and one chroma sample in bits 9:0. Both samples are captured on a clock edge where the word strobe is high. Each 10-bit half then passes, on its own, through a sync-code mapper. When the upper eight bits of a half are all zeros, the mapper forces its two low bits to zero. When they are all ones, it forces them to one. This lets an 8-bit source deliver timing-reference codes that a 10-bit receiver reads correctly.

After mapping, the pair is sent out as a 10-bit stream, one sample per cycle: chroma first, then luma. A phase flag marks which sample is on the bus. The block runs on one clock at the sample rate, which is twice the word rate. Words may be strobed at most every second cycle. A disable input, sampled together with each word, turns the mapping off for data that does not follow the video code rules.

The capture side has a two-state machine:
- CAP_IDLE: ready to accept a word. A strobe latches the word and moves to CAP_MAP.
- CAP_MAP: the mapped pair is registered, and the machine always returns to CAP_IDLE. A strobe in this state is ignored.

The output side has a three-state machine:
- EMIT_IDLE: output not valid. If a pair is ready, move to EMIT_CHROMA.
- EMIT_CHROMA: always moves to EMIT_LUMA.
- EMIT_LUMA: move to EMIT_CHROMA if a new pair is ready, otherwise to EMIT_IDLE.

Top module: `ycmap_interleaver`

## Requirements
- R1: After reset, and until the first word is accepted, `ser_valid`, `ser_is_luma` and `ser_word` are all 0.
- R2: A word captured at clock edge t shows its chroma half (input bits 9:0) on `ser_word` after edge t+2, with `ser_valid`=1 and `ser_is_luma`=0.
- R3: The luma half (input bits 19:10) of the same word follows after edge t+3, with `ser_valid`=1 and `ser_is_luma`=1. Every luma output comes directly after a chroma output.
- R4: With mapping enabled (`map_off`=0), a half whose bits 9:2 are all zero comes out with bits 1:0 = 00. So 0x000 to 0x003 all come out as 0x000.
- R5: With mapping enabled, a half whose bits 9:2 are all one comes out with bits 1:0 = 11. So 0x3FC to 0x3FF all come out as 0x3FF.
- R6: With mapping enabled, every other code passes through unchanged.
- R7: With `map_off`=1, every one of the 1024 codes passes through unchanged on both halves, reserved codes included.
- R8: The two halves are mapped independently: the result for one half does not depend on the value of the other.
- R9: A strobe on the edge directly after a capture is ignored. The held word is not replaced, and no extra output pair appears.
- R10: Strobes every second cycle produce a continuous output stream with no gaps. `ser_valid` falls to 0 on the cycle after the last luma output when no further word follows.
- R11: `map_off` is sampled at the capture edge together with the word. A change to `map_off` after that edge does not affect the word already captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock (twice the word rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| map_off | input | 1 | 1 = pass codes unchanged, 0 = apply sync-code mapping |
| word_stb | input | 1 | Capture `word_in` on this edge |
| word_in | input | 20 | Luma in bits 19:10, chroma in bits 9:0 |
| ser_word | output | 10 | Interleaved sample |
| ser_valid | output | 1 | `ser_word` holds a sample |
| ser_is_luma | output | 1 | 1 = luma sample, 0 = chroma sample |

## Verification
The bench builds the block with its default parameters: 10-bit samples and two forced low bits. With these values the whole code space is small enough to sweep. Every one of the 1024 codes is applied on the luma half and, in reverse order, on the chroma half, once with mapping on and once with it off. Both reserved ranges and all their neighbours are therefore checked on each lane. The directed tests then cover the output order, a strobe that arrives too early, a change of `map_off` after capture, and a back-to-back stream followed by its falling edge.

// File: rtl/ycmap_pkg.sv
package ycmap_pkg;

    // Capture side: whether a word is waiting to be mapped.
    typedef enum logic [0:0] {
        CAP_IDLE = 1'b0,
        CAP_MAP  = 1'b1
    } cap_state_e;

    // Output side: which sample of the pair is on the bus.
    typedef enum logic [1:0] {
        EMIT_IDLE   = 2'd0,
        EMIT_CHROMA = 2'd1,
        EMIT_LUMA   = 2'd2
    } emit_state_e;

endpackage

// File: rtl/ycmap_lane_map.sv
// Sync-code mapper for one sample lane.
module ycmap_lane_map #(
    parameter int SAMPLE_W   = 10,
    parameter int FORCE_LSBS = 2
) (
    input  logic [SAMPLE_W-1:0] code_in,
    input  logic                bypass,
    output logic [SAMPLE_W-1:0] code_out
);
    localparam int HIGH_W = SAMPLE_W - FORCE_LSBS;

    logic [HIGH_W-1:0] high_part;
    logic              high_zero;
    logic              high_ones;

    assign high_part = code_in[SAMPLE_W-1:FORCE_LSBS];
    assign high_zero = ~|high_part;
    assign high_ones = &high_part;

    always_comb begin
        if (bypass) begin
            code_out = code_in;
        end else if (high_zero) begin
            code_out = {high_part, {FORCE_LSBS{1'b0}}};
        end else if (high_ones) begin
            code_out = {high_part, {FORCE_LSBS{1'b1}}};
        end else begin
            code_out = code_in;
        end
    end
endmodule

// File: rtl/ycmap_capture.sv
// Word latch with its disable flag, followed by one registered mapping stage.
module ycmap_capture
    import ycmap_pkg::*;
#(
    parameter int SAMPLE_W   = 10,
    parameter int FORCE_LSBS = 2,
    parameter int LANES      = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      stb,
    input  logic                      off_in,
    input  logic [LANES*SAMPLE_W-1:0] word_in,
    output logic [LANES*SAMPLE_W-1:0] pair_q,
    output logic                      pair_vld
);
    localparam int WORD_W = LANES * SAMPLE_W;

    cap_state_e        state_q, state_d;
    logic [WORD_W-1:0] latch_q;
    logic              off_q;
    logic [WORD_W-1:0] mapped;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ycmap_lane_map #(
            .SAMPLE_W  (SAMPLE_W),
            .FORCE_LSBS(FORCE_LSBS)
        ) map_i (
            .code_in (latch_q[g*SAMPLE_W +: SAMPLE_W]),
            .bypass  (off_q),
            .code_out(mapped[g*SAMPLE_W +: SAMPLE_W])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: if (stb) state_d = CAP_MAP;
            CAP_MAP:  state_d = CAP_IDLE;
            default:  state_d = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q  <= '0;
            off_q    <= 1'b0;
            pair_q   <= '0;
            pair_vld <= 1'b0;
        end else begin
            pair_vld <= 1'b0;
            unique case (state_q)
                CAP_IDLE: begin
                    if (stb) begin
                        latch_q <= word_in;
                        off_q   <= off_in;
                    end
                end
                CAP_MAP: begin
                    pair_q   <= mapped;
                    pair_vld <= 1'b1;
                end
                default: pair_vld <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ycmap_emit.sv
// Sends a mapped pair out one sample per cycle, chroma (lane 0) first.
module ycmap_emit
    import ycmap_pkg::*;
#(
    parameter int SAMPLE_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*SAMPLE_W-1:0] pair_q,
    input  logic                  pair_vld,
    output logic [SAMPLE_W-1:0]   ser_word,
    output logic                  ser_valid,
    output logic                  ser_is_luma
);
    emit_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EMIT_IDLE:   state_d = pair_vld ? EMIT_CHROMA : EMIT_IDLE;
            EMIT_CHROMA: state_d = EMIT_LUMA;
            EMIT_LUMA:   state_d = pair_vld ? EMIT_CHROMA : EMIT_IDLE;
            default:     state_d = EMIT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EMIT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_word    <= '0;
            ser_valid   <= 1'b0;
            ser_is_luma <= 1'b0;
        end else begin
            unique case (state_d)
                EMIT_CHROMA: begin
                    ser_word    <= pair_q[SAMPLE_W-1:0];
                    ser_valid   <= 1'b1;
                    ser_is_luma <= 1'b0;
                end
                EMIT_LUMA: begin
                    ser_word    <= pair_q[2*SAMPLE_W-1:SAMPLE_W];
                    ser_valid   <= 1'b1;
                    ser_is_luma <= 1'b1;
                end
                default: begin
                    ser_valid   <= 1'b0;
                    ser_is_luma <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ycmap_interleaver.sv
module ycmap_interleaver #(
    parameter int SAMPLE_W   = 10,
    parameter int FORCE_LSBS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  map_off,
    input  logic                  word_stb,
    input  logic [2*SAMPLE_W-1:0] word_in,
    output logic [SAMPLE_W-1:0]   ser_word,
    output logic                  ser_valid,
    output logic                  ser_is_luma
);
    localparam int LANES  = 2;
    localparam int WORD_W = LANES * SAMPLE_W;

    logic [WORD_W-1:0] pair_q;
    logic              pair_vld;

    ycmap_capture #(
        .SAMPLE_W  (SAMPLE_W),
        .FORCE_LSBS(FORCE_LSBS),
        .LANES     (LANES)
    ) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (word_stb),
        .off_in  (map_off),
        .word_in (word_in),
        .pair_q  (pair_q),
        .pair_vld(pair_vld)
    );

    ycmap_emit #(
        .SAMPLE_W(SAMPLE_W)
    ) emit_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_q     (pair_q),
        .pair_vld   (pair_vld),
        .ser_word   (ser_word),
        .ser_valid  (ser_valid),
        .ser_is_luma(ser_is_luma)
    );
endmodule

// File: rtl/ycmap_interleaver_chk.sv
module ycmap_interleaver_chk #(
    parameter int SAMPLE_W   = 10,
    parameter int FORCE_LSBS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  map_off,
    input logic                  word_stb,
    input logic [2*SAMPLE_W-1:0] word_in,
    input logic [SAMPLE_W-1:0]   ser_word,
    input logic                  ser_valid,
    input logic                  ser_is_luma
);
    logic chroma_out;
    logic luma_out;
    logic high_zero;
    logic high_ones;

    assign chroma_out = ser_valid && !ser_is_luma;
    assign luma_out   = ser_valid && ser_is_luma;
    assign high_zero  = ~|ser_word[SAMPLE_W-1:FORCE_LSBS];
    assign high_ones  = &ser_word[SAMPLE_W-1:FORCE_LSBS];

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !ser_valid && !ser_is_luma);

    assert_chroma_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chroma_out |-> $past(word_stb, 3));

    assert_luma_after_chroma_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chroma_out |=> luma_out);

    assert_luma_has_chroma_R3: assert property (@(posedge clk) disable iff (!rst_n)
        luma_out |-> $past(chroma_out));

    assert_zero_forced_chroma_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chroma_out && !$past(map_off, 3) && high_zero |-> ser_word[FORCE_LSBS-1:0] == '0);

    assert_zero_forced_luma_R4: assert property (@(posedge clk) disable iff (!rst_n)
        luma_out && !$past(map_off, 4) && high_zero |-> ser_word[FORCE_LSBS-1:0] == '0);

    assert_ones_forced_chroma_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chroma_out && !$past(map_off, 3) && high_ones |-> &ser_word[FORCE_LSBS-1:0]);

    assert_ones_forced_luma_R5: assert property (@(posedge clk) disable iff (!rst_n)
        luma_out && !$past(map_off, 4) && high_ones |-> &ser_word[FORCE_LSBS-1:0]);

    assert_bypass_chroma_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chroma_out && $past(map_off, 3) |-> ser_word == $past(word_in[SAMPLE_W-1:0], 3));

    assert_bypass_luma_R7: assert property (@(posedge clk) disable iff (!rst_n)
        luma_out && $past(map_off, 4) |-> ser_word == $past(word_in[2*SAMPLE_W-1:SAMPLE_W], 4));
endmodule

bind ycmap_interleaver ycmap_interleaver_chk #(
    .SAMPLE_W  (SAMPLE_W),
    .FORCE_LSBS(FORCE_LSBS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .map_off    (map_off),
    .word_stb   (word_stb),
    .word_in    (word_in),
    .ser_word   (ser_word),
    .ser_valid  (ser_valid),
    .ser_is_luma(ser_is_luma)
);

// File: tb/ycmap_interleaver_tb_top.sv
module ycmap_interleaver_tb_top;
    localparam int W = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           map_off = 1'b0;
    logic           word_stb = 1'b0;
    logic [2*W-1:0] word_in = '0;
    logic [W-1:0]   ser_word;
    logic           ser_valid;
    logic           ser_is_luma;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ycmap_interleaver #(.SAMPLE_W(W), .FORCE_LSBS(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .map_off    (map_off),
        .word_stb   (word_stb),
        .word_in    (word_in),
        .ser_word   (ser_word),
        .ser_valid  (ser_valid),
        .ser_is_luma(ser_is_luma)
    );

    function automatic logic [W-1:0] model_map(input logic [W-1:0] v, input logic off);
        if (off)                 return v;
        if (v[W-1:2] == '0)      return {v[W-1:2], 2'b00};
        if (&v[W-1:2])           return {v[W-1:2], 2'b11};
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Check the three outputs in one go.
    task automatic check_out(input string tag, input logic v, input logic l, input logic [W-1:0] w);
        check({tag, " valid"}, {31'b0, ser_valid}, {31'b0, v});
        if (v) begin
            check({tag, " phase"}, {31'b0, ser_is_luma}, {31'b0, l});
            check({tag, " word"}, {22'b0, ser_word}, {22'b0, w});
        end
    endtask

    // One isolated word: capture edge, then chroma and luma checked in place.
    task automatic one_word(input string tag, input logic [W-1:0] l, input logic [W-1:0] c,
                            input logic off);
        @(negedge clk);
        word_stb = 1'b1; word_in = {l, c}; map_off = off;
        @(negedge clk);
        word_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_out({tag, " chroma"}, 1'b1, 1'b0, model_map(c, off));
        @(negedge clk);
        check_out({tag, " luma"}, 1'b1, 1'b1, model_map(l, off));
    endtask

    task automatic test_reset;
        check_out("R1 reset", 1'b0, 1'b0, '0);
        check("R1 reset word", {22'b0, ser_word}, 32'h0);
        check("R1 reset phase", {31'b0, ser_is_luma}, 32'h0);
    endtask

    task automatic test_sweep(input logic off);
        for (int k = 0; k < 1024; k++) begin
            logic [W-1:0] l;
            logic [W-1:0] c;
            l = W'(k);
            c = W'(1023 - k);
            if (off) one_word("R7 bypass sweep", l, c, 1'b1);
            else if (l[W-1:2] == '0 || c[W-1:2] == '0) one_word("R4 zero map sweep", l, c, 1'b0);
            else if (&l[W-1:2] || &c[W-1:2]) one_word("R5 ones map sweep", l, c, 1'b0);
            else one_word("R6 plain sweep", l, c, 1'b0);
        end
    endtask

    task automatic test_independent;
        one_word("R8 mixed lanes a", 10'h002, 10'h3FD, 1'b0);
        one_word("R8 mixed lanes b", 10'h155, 10'h001, 1'b0);
        one_word("R8 mixed lanes c", 10'h3FE, 10'h204, 1'b0);
    endtask

    task automatic test_early_strobe;
        @(negedge clk);
        word_stb = 1'b1; word_in = {10'h0AB, 10'h1CD}; map_off = 1'b0;
        @(negedge clk);
        word_in = {10'h3FD, 10'h002};          // strobe still high: must be ignored
        @(negedge clk);
        word_stb = 1'b0;
        @(negedge clk);
        check_out("R9 held chroma", 1'b1, 1'b0, 10'h1CD);
        @(negedge clk);
        check_out("R9 held luma", 1'b1, 1'b1, 10'h0AB);
        @(negedge clk);
        check_out("R9 no extra pair", 1'b0, 1'b0, '0);
        @(negedge clk);
        check_out("R9 still idle", 1'b0, 1'b0, '0);
    endtask

    task automatic test_late_off;
        @(negedge clk);
        word_stb = 1'b1; word_in = {10'h3FC, 10'h001}; map_off = 1'b0;
        @(negedge clk);
        word_stb = 1'b0; map_off = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_out("R11 chroma mapped", 1'b1, 1'b0, 10'h000);
        @(negedge clk);
        check_out("R11 luma mapped", 1'b1, 1'b1, 10'h3FF);
        map_off = 1'b0;
    endtask

    task automatic test_stream;
        logic [W-1:0] sl [8];
        logic [W-1:0] sc [8];
        for (int k = 0; k < 8; k++) begin
            sl[k] = W'(10'h3FC + k * 37);
            sc[k] = W'(k * 129 + 1);
        end
        for (int n = 0; n < 22; n++) begin
            @(negedge clk);
            if (n >= 3 && (n % 2) == 1 && (n - 3) / 2 < 8)
                check_out("R10 stream chroma", 1'b1, 1'b0, model_map(sc[(n - 3) / 2], 1'b0));
            else if (n >= 4 && (n % 2) == 0 && (n - 4) / 2 < 8)
                check_out("R10 stream luma", 1'b1, 1'b1, model_map(sl[(n - 4) / 2], 1'b0));
            else if (n >= 20)
                check_out("R10 stream end", 1'b0, 1'b0, '0);
            if ((n % 2) == 0 && n / 2 < 8) begin
                word_stb = 1'b1; word_in = {sl[n / 2], sc[n / 2]}; map_off = 1'b0;
            end else begin
                word_stb = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        one_word("R2 R3 order", 10'h2A5, 10'h15A, 1'b0);
        one_word("R4 reserved low", 10'h003, 10'h001, 1'b0);
        one_word("R5 reserved high", 10'h3FC, 10'h3FE, 1'b0);
        one_word("R7 reserved kept", 10'h003, 10'h3FC, 1'b1);
        test_sweep(1'b0);
        test_sweep(1'b1);
        test_independent();
        test_early_strobe();
        test_late_off();
        test_stream();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule